// File: doc/BRIEF.md
# Registered Eight-Operation ALU

This block is a small integer datapath that applies one of eight operations to two unsigned operands of a configurable width and holds the answer in a single output register. A three-bit operation code selects the work to do: its most significant bit picks between an arithmetic group and a bitwise group, and its two low bits pick the operation inside that group.

The operation code and both operands are captured on every rising clock edge, and the matching result is visible from that edge onward, one cycle after the inputs were presented. A new operation may be issued on every cycle; there is no handshake or stall. All arithmetic wraps inside the operand width, and the product keeps only its low bits. The block carries no flags and gives operands no signed meaning.

Top module: `alu8_datapath`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `result` becomes all zeros at that edge, whatever the other inputs are.
- R2: With `rst_n` high, the value of `result` after a rising edge is the outcome of the `op_code`, `op_a` and `op_b` sampled at that same edge, so each result is due one cycle after its inputs, and back-to-back operations on consecutive cycles each produce their own result.
- R3: Code 3'b100 gives `op_a + op_b` modulo 2^WIDTH, with no carry out.
- R4: Code 3'b101 gives `op_a - op_b` modulo 2^WIDTH, with no borrow out.
- R5: Code 3'b110 gives the low WIDTH bits of the full unsigned product `op_a * op_b`.
- R6: Code 3'b111 gives the two's-complement negation of `op_a` (0 - `op_a` modulo 2^WIDTH); `op_b` has no effect on the result.
- R7: Code 3'b000 gives the bitwise AND of `op_a` and `op_b`.
- R8: Code 3'b001 gives the bitwise OR of `op_a` and `op_b`.
- R9: Code 3'b010 gives the bitwise XOR of `op_a` and `op_b`.
- R10: Code 3'b011 gives the bitwise inversion of `op_a`; `op_b` has no effect on the result.
- R11: With WIDTH set to 3, every one of the 512 combinations of code and operands produces the result named by R3 to R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 3 | Operation select: bit 2 high for arithmetic, low for bitwise; bits 1:0 pick the operation |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand, unused by negate and invert |
| result | output | WIDTH | Registered result of the operation sampled at the previous rising edge |

## Verification
Every result is due exactly one clock after its inputs are captured, and reset takes effect at the same edge at which it is sampled low. The bench drives a new code and operand pair at each falling edge, pushes the expected value into a queue, and at the following falling edge, after exactly one rising edge, pops and compares it against `result`. Reset is checked the same way: inputs held nonzero with `rst_n` low, then `result` read one edge later, both at start and in the middle of the stream, after which the queue is emptied so stale expectations cannot match.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Shared encodings for the eight-operation ALU. The operation code is a
// packed struct: a group bit on top and a two-bit selector below it.
// Assumes the code layout is fixed at three bits regardless of WIDTH.
package alu8_pkg;

    // Bit position of the group selector inside the operation code.
    localparam int unsigned GROUP_BIT = 2;
    localparam int unsigned CODE_W    = 3;

    // Operation selector inside the arithmetic group.
    typedef enum logic [1:0] {
        ARITH_SUM  = 2'b00,
        ARITH_DIFF = 2'b01,
        ARITH_PROD = 2'b10,
        ARITH_NEG  = 2'b11
    } arith_sel_e;

    // Operation selector inside the bitwise group.
    typedef enum logic [1:0] {
        BITW_AND = 2'b00,
        BITW_OR  = 2'b01,
        BITW_XOR = 2'b10,
        BITW_INV = 2'b11
    } bitw_sel_e;

    // Decoded operation code.
    typedef struct packed {
        logic       is_arith;
        logic [1:0] sel;
    } op_word_t;

endpackage

// File: rtl/alu8_arith.sv
// Module alu8_arith
// Combinational arithmetic group: wrap-around sum and difference, the
// truncated product and the two's-complement negation of operand A.
// Assumes unsigned operands; no carry, borrow or overflow is produced.
// MUL_SHIFT_ADD picks the product form: 0 uses the width-limited product
// operator, 1 builds a truncated shift-and-add array.
module alu8_arith #(
    parameter int unsigned WIDTH         = 16,
    parameter bit          MUL_SHIFT_ADD = 1'b0
) (
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    import alu8_pkg::*;

    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] diff_w;
    logic [WIDTH-1:0] prod_w;
    logic [WIDTH-1:0] neg_w;

    // Sum and difference wrap naturally at WIDTH bits.
    always_comb begin
        sum_w  = a + b;
        diff_w = a - b;
        neg_w  = ZERO - a;
    end

    generate
        if (MUL_SHIFT_ADD) begin : g_mul_array
            // Partial products kept at WIDTH bits: upper bits never formed.
            logic [WIDTH-1:0] part [WIDTH];
            logic [WIDTH-1:0] acc  [WIDTH+1];

            // Build each shifted partial product gated by one bit of b.
            always_comb begin
                for (int i = 0; i < WIDTH; i++) begin
                    part[i] = b[i] ? (a << i) : ZERO;
                end
            end

            // Accumulate the partial products modulo 2^WIDTH.
            always_comb begin
                acc[0] = ZERO;
                for (int i = 0; i < WIDTH; i++) begin
                    acc[i+1] = acc[i] + part[i];
                end
            end

            assign prod_w = acc[WIDTH];
        end else begin : g_mul_op
            // Product operator sized to WIDTH keeps only the low bits.
            assign prod_w = a * b;
        end
    endgenerate

    // Select the requested arithmetic result.
    always_comb begin
        unique case (arith_sel_e'(sel))
            ARITH_SUM:  y = sum_w;
            ARITH_DIFF: y = diff_w;
            ARITH_PROD: y = prod_w;
            ARITH_NEG:  y = neg_w;
            default:    y = ZERO;
        endcase
    end

endmodule

// File: rtl/alu8_bitwise.sv
// Module alu8_bitwise
// Combinational bitwise group: AND, OR, XOR and inversion of operand A.
// Assumes nothing about operand meaning; each bit is treated alone.
module alu8_bitwise #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    import alu8_pkg::*;

    // Select the requested bitwise function.
    always_comb begin
        unique case (bitw_sel_e'(sel))
            BITW_AND: y = a & b;
            BITW_OR:  y = a | b;
            BITW_XOR: y = a ^ b;
            BITW_INV: y = ~a;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/alu8_result_reg.sv
// Module alu8_result_reg
// Output stage: a WIDTH-bit register loaded on every rising edge.
// Assumes a synchronous active-low reset that clears it to zero.
module alu8_result_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture the next result, or clear it while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu8_datapath.sv
// Module alu8_datapath
// Top of the eight-operation ALU. Decodes the operation code, evaluates
// both groups in parallel, picks one by the group bit and registers it.
// Assumes WIDTH >= 3 and that a new code may arrive on every cycle.
module alu8_datapath #(
    parameter int unsigned WIDTH         = 16,
    parameter bit          MUL_SHIFT_ADD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result
);
    import alu8_pkg::*;

    op_word_t         op_w;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] bitw_y;
    logic [WIDTH-1:0] next_y;

    // Split the raw code into group bit and selector.
    always_comb begin
        op_w.is_arith = op_code[GROUP_BIT];
        op_w.sel      = op_code[1:0];
    end

    alu8_arith #(
        .WIDTH         (WIDTH),
        .MUL_SHIFT_ADD (MUL_SHIFT_ADD)
    ) u_arith (
        .sel (op_w.sel),
        .a   (op_a),
        .b   (op_b),
        .y   (arith_y)
    );

    alu8_bitwise #(
        .WIDTH (WIDTH)
    ) u_bitwise (
        .sel (op_w.sel),
        .a   (op_a),
        .b   (op_b),
        .y   (bitw_y)
    );

    // Choose between the arithmetic and bitwise group outputs.
    always_comb begin
        next_y = op_w.is_arith ? arith_y : bitw_y;
    end

    alu8_result_reg #(
        .WIDTH (WIDTH)
    ) u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_y),
        .q     (result)
    );

endmodule

// File: rtl/alu8_datapath_chk.sv
// Module alu8_datapath_chk
// Property checker bound to alu8_datapath. Compares the registered result
// against the previous cycle's code and operands.
module alu8_datapath_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_code,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] result
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    // R1: a low reset sample clears the result at that edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (result == ZERO));

    // R3: sum wraps at WIDTH bits.
    a_r3_sum_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b100) |=> (result == WIDTH'($past(op_a) + $past(op_b))));

    // R4: difference wraps at WIDTH bits.
    a_r4_diff_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b101) |=> (result == WIDTH'($past(op_a) - $past(op_b))));

    // R5: product keeps only the low bits.
    a_r5_prod_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b110) |=> (result == WIDTH'($past(op_a) * $past(op_b))));

    // R6: negation of A.
    a_r6_negate_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b111) |=> (result == WIDTH'(ZERO - $past(op_a))));

    // R7: bitwise AND.
    a_r7_and: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b000) |=> (result == ($past(op_a) & $past(op_b))));

    // R8: bitwise OR.
    a_r8_or: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b001) |=> (result == ($past(op_a) | $past(op_b))));

    // R9: bitwise XOR.
    a_r9_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b010) |=> (result == ($past(op_a) ^ $past(op_b))));

    // R10: inversion of A.
    a_r10_invert_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'b011) |=> (result == ~$past(op_a)));

    // R2: with inputs held over two edges the result holds as well.
    a_r2_hold_when_inputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(op_code) && $stable(op_a) && $stable(op_b))
        |=> $stable(result));

endmodule

bind alu8_datapath alu8_datapath_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .op_a    (op_a),
    .op_b    (op_b),
    .result  (result)
);

// File: tb/alu8_datapath_bench.sv
// Bench for alu8_datapath at WIDTH = 3: exhaustive sweep against a
// behavioural reference held in a queue, compared on every clock.
module alu8_datapath_bench;

    localparam int W    = 3;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_code = '0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    int exp_q [$];
    int tag_q [$];

    alu8_datapath #(.WIDTH(W)) u_alu8_datapath (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_code (op_code),
        .op_a    (op_a),
        .op_b    (op_b),
        .result  (result)
    );

    always #2 clk = ~clk;

    // Reference model from the requirements, in plain integers.
    function automatic int model(int code, int a, int b);
        case (code)
            4: return (a + b) & MASK;
            5: return (a - b) & MASK;
            6: return (a * b) & MASK;
            7: return (0 - a) & MASK;
            0: return a & b;
            1: return a | b;
            2: return a ^ b;
            default: return (~a) & MASK;
        endcase
    endfunction

    function automatic string tag_of(int code);
        case (code)
            4: return "R3";
            5: return "R4";
            6: return "R5";
            7: return "R6";
            0: return "R7";
            1: return "R8";
            2: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // At a falling edge: compare the pending result, then present new inputs.
    task automatic issue(int code, int a, int b, string req);
        @(negedge clk);
        if (exp_q.size() > 0) begin
            check({tag_q.pop_front() == 0 ? "" : "", req_pending}, int'(result), exp_q.pop_front());
        end
        op_code = 3'(code);
        op_a    = W'(a);
        op_b    = W'(b);
        exp_q.push_back(model(code, a, b));
        tag_q.push_back(0);
        req_pending = req;
    endtask

    string req_pending = "R2";

    task automatic drain();
        @(negedge clk);
        if (exp_q.size() > 0) begin
            void'(tag_q.pop_front());
            check(req_pending, int'(result), exp_q.pop_front());
        end
    endtask

    initial begin
        // R1: reset with nonzero inputs gives zero.
        op_code = 3'b100; op_a = 3'd5; op_b = 3'd6;
        repeat (3) @(negedge clk);
        check("R1", int'(result), 0);
        rst_n = 1'b1;

        // R2: back-to-back distinct operations each land one cycle later.
        issue(4, 3, 2, "R2");
        issue(6, 7, 7, "R2");
        issue(0, 5, 3, "R2");
        issue(7, 1, 4, "R2");
        drain();

        // R6 and R10: operand B has no effect.
        for (int b = 0; b <= MASK; b++) issue(7, 3, b, "R6");
        for (int b = 0; b <= MASK; b++) issue(3, 5, b, "R10");
        drain();

        // R1: reset in the middle of a stream.
        issue(1, 6, 1, "R8");
        @(negedge clk);
        void'(tag_q.pop_front());
        check(req_pending, int'(result), exp_q.pop_front());
        rst_n = 1'b0;
        op_code = 3'b110; op_a = 3'd7; op_b = 3'd3;
        @(negedge clk);
        check("R1", int'(result), 0);
        rst_n = 1'b1;

        // R11 with R3 to R10: exhaustive sweep of code and operands.
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    issue(c, a, b, {"R11/", tag_of(c)});
                end
            end
        end
        drain();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #40000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule